// File: doc/BRIEF.md
# Timestamped Event Code Sequencer

This block plays out a short, programmed list of 8-bit event codes on an event-clock-rate output. Each table slot holds an event code, a timestamp counted in event-clock ticks, and a valid flag. A synchronizer pulse starts a run. The run's time count starts at zero and goes up by one every cycle. A slot's code goes out in the cycle in which the count equals that slot's effective time. The run stops after the latest effective time among the valid slots.

Arbitrary bucket injection is handled by a bucket number that is sampled when the run starts. One event tick spans four RF buckets, so the coarse shift is the bucket number divided by four, rounded down. This shift is added to the time of every injection-chain code. The ring diagnostic code, and any code outside the injection chain, keeps the time it was written with. The table is loaded through a simple write port. Writes are refused while a run is in progress, so a running sequence cannot be corrupted.

Top module: `evt_sequencer`

## Requirements
- R1: After reset, `evtCode` is 0x00 and `busy` is 0.
- R2: A write with `cfgWrEn` high while idle stores `cfgCode`, `cfgStamp` and `cfgValid` into slot `cfgAddr`.
- R3: A `syncPulse` sampled while idle starts a run. `busy` is high from the next cycle on. A slot with effective time T drives its code on `evtCode` in the cycle T+1 clock edges after the start edge.
- R4: `evtCode` is 0x00 (no event) in every cycle in which no slot matches, and at all times while idle.
- R5: The injection-chain codes 0x02, 0x03, 0x04, 0x06, 0x07 and 0x08 have effective time = stored timestamp + floor(bucket/4). For example, bucket 3 adds 0 and bucket 13 adds 3.
- R6: Code 0x01, and every code not listed in R5, has effective time equal to its stored timestamp, whatever the bucket.
- R7: The bucket number is captured at the start edge. A change to `bucketNum` during a run has no effect on that run.
- R8: Slots whose valid flag is 0 are never emitted and do not extend the run. `busy` falls in the cycle after the edge on which the count reaches the largest valid effective time. The slot order in the table does not affect when any code is emitted.
- R9: A `syncPulse` that arrives while `busy` is high is ignored: the run's timing and its end are unchanged.
- R10: Table writes issued while `busy` is high are discarded.
- R11: When several valid slots share an effective time, only the code of the lowest-index slot is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Table write strobe |
| cfgAddr | input | ADDR_W | Slot index to write |
| cfgCode | input | 8 | Event code for the slot |
| cfgStamp | input | TS_W | Timestamp in event ticks |
| cfgValid | input | 1 | Slot valid flag |
| bucketNum | input | BUCKET_W | Target bucket number, sampled at start |
| syncPulse | input | 1 | Start pulse from the mains/coincidence synchronizer |
| evtCode | output | 8 | Event code stream, 0x00 when no event |
| busy | output | 1 | A run is in progress |

## Verification
The hardest case to reach is a shifted injection code that ends up after an unshifted diagnostic code even though the table lists the injection code first. A plain read pointer would miss one of the two codes in this case. The bench writes the table in such an order and uses a bucket whose quarter pushes the gun code past the diagnostic time, then checks the exact cycle of both codes. Collisions are forced the same way: a shifted code is placed so that it lands on another slot's time. Restart pulses, bucket changes and table writes are injected at chosen cycles in the middle of a run, and the run is then compared with an undisturbed one.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;

  typedef logic [7:0] evtCode_t;

  localparam evtCode_t CODE_NONE = 8'h00;

  // Strobes from control to datapath
  typedef struct packed {
    logic runStart;  // clear count, capture bucket
    logic runStep;   // advance count, allow emission
  } seqStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

  // Codes of the injection chain move with the bucket
  function automatic logic codeFollowsBucket(input evtCode_t code);
    case (code)
      8'h02, 8'h03, 8'h04, 8'h06, 8'h07, 8'h08: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evt_seq_table.sv
module evt_seq_table
  import evt_seq_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TS_W    = 16,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lock,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  evtCode_t                       wrCode,
  input  logic [TS_W-1:0]                wrStamp,
  input  logic                           wrValid,
  output logic [ENTRIES-1:0][7:0]        slotCode,
  output logic [ENTRIES-1:0][TS_W-1:0]   slotStamp,
  output logic [ENTRIES-1:0]             slotValid
);

  logic wrAccept;
  assign wrAccept = wrEn && !lock && (int'(wrAddr) < ENTRIES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCode  <= '0;
      slotStamp <= '0;
      slotValid <= '0;
    end else if (wrAccept) begin
      slotCode[wrAddr]  <= wrCode;
      slotStamp[wrAddr] <= wrStamp;
      slotValid[wrAddr] <= wrValid;
    end
  end

  // R10: a locked write leaves the table untouched
  assert_locked_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lock && wrEn) |=> ($stable(slotCode) && $stable(slotStamp) && $stable(slotValid)));

endmodule

// File: rtl/evt_seq_match.sv
module evt_seq_match
  import evt_seq_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int TS_W     = 16,
  parameter int BUCKET_W = 10,
  localparam int CNT_W   = TS_W + 1
) (
  input  logic [ENTRIES-1:0][7:0]        slotCode,
  input  logic [ENTRIES-1:0][TS_W-1:0]   slotStamp,
  input  logic [ENTRIES-1:0]             slotValid,
  input  logic [BUCKET_W-1:0]            coarseShift,
  input  logic [CNT_W-1:0]               timeCount,
  output logic                           hitAny,
  output evtCode_t                       hitCode,
  output logic [CNT_W-1:0]               lastTime
);

  logic [ENTRIES-1:0][CNT_W-1:0] effTime;
  logic [ENTRIES-1:0]            slotHit;
  logic [CNT_W-1:0]              shiftExt;

  assign shiftExt = CNT_W'(coarseShift);

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
    always_comb begin
      effTime[gi] = CNT_W'(slotStamp[gi]);
      if (codeFollowsBucket(slotCode[gi])) effTime[gi] = effTime[gi] + shiftExt;
    end
    assign slotHit[gi] = slotValid[gi] && (effTime[gi] == timeCount);
  end

  // Lowest index wins on a tie
  always_comb begin
    hitAny  = 1'b0;
    hitCode = CODE_NONE;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (slotHit[i]) begin
        hitAny  = 1'b1;
        hitCode = slotCode[i];
      end
    end
  end

  // Run length: latest valid effective time
  always_comb begin
    lastTime = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (slotValid[i] && (effTime[i] > lastTime)) lastTime = effTime[i];
    end
  end

endmodule

// File: rtl/evt_seq_dpath.sv
module evt_seq_dpath
  import evt_seq_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int TS_W     = 16,
  parameter int BUCKET_W = 10,
  localparam int ADDR_W  = $clog2(ENTRIES),
  localparam int CNT_W   = TS_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobes_t           strb,
  input  logic                  busy,
  input  logic                  cfgWrEn,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  evtCode_t              cfgCode,
  input  logic [TS_W-1:0]       cfgStamp,
  input  logic                  cfgValid,
  input  logic [BUCKET_W-1:0]   bucketNum,
  output logic                  atLast,
  output evtCode_t              evtCode
);

  logic [ENTRIES-1:0][7:0]      slotCode;
  logic [ENTRIES-1:0][TS_W-1:0] slotStamp;
  logic [ENTRIES-1:0]           slotValid;
  logic [BUCKET_W-1:0]          shiftReg;
  logic [CNT_W-1:0]             countReg;
  logic [CNT_W-1:0]             lastTime;
  logic                         hitAny;
  evtCode_t                     hitCode;

  evt_seq_table #(.ENTRIES(ENTRIES), .TS_W(TS_W)) i_table (
    .clk(clk), .rstN(rstN), .lock(busy),
    .wrEn(cfgWrEn), .wrAddr(cfgAddr), .wrCode(cfgCode),
    .wrStamp(cfgStamp), .wrValid(cfgValid),
    .slotCode(slotCode), .slotStamp(slotStamp), .slotValid(slotValid)
  );

  evt_seq_match #(.ENTRIES(ENTRIES), .TS_W(TS_W), .BUCKET_W(BUCKET_W)) i_match (
    .slotCode(slotCode), .slotStamp(slotStamp), .slotValid(slotValid),
    .coarseShift(shiftReg), .timeCount(countReg),
    .hitAny(hitAny), .hitCode(hitCode), .lastTime(lastTime)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      countReg <= '0;
    end else if (strb.runStart) begin
      shiftReg <= bucketNum >> 2;   // four RF buckets per event tick
      countReg <= '0;
    end else if (strb.runStep && !atLast) begin
      countReg <= countReg + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       evtCode <= CODE_NONE;
    else if (strb.runStep && hitAny) evtCode <= hitCode;
    else                             evtCode <= CODE_NONE;
  end

  assign atLast = (countReg == lastTime);

  // R4: no step, no event in the following cycle
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.runStep |=> (evtCode == CODE_NONE));

  // R7: the captured shift holds for the whole run
  assert_bucket_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.runStep && !strb.runStart) |=> $stable(shiftReg));

  // R8: the count never passes the end of the run
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.runStep |-> (countReg <= lastTime));

endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
  import evt_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncPulse,
  input  logic        atLast,
  output seqStrobes_t strb,
  output logic        busy
);

  seqState_t state, stateNext;

  always_comb begin
    strb.runStart = (state == ST_IDLE) && syncPulse;
    strb.runStep  = (state == ST_RUN);
    stateNext     = state;
    case (state)
      ST_IDLE: if (syncPulse) stateNext = ST_RUN;
      ST_RUN:  if (atLast)    stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_RUN);

  // R3: an idle start enters the run
  assert_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && syncPulse) |=> busy);

  // R9: a run continues until its end regardless of new pulses
  assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !atLast) |=> busy);

  // R8: the run ends right after its last time
  assert_run_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && atLast) |=> !busy);

endmodule

// File: rtl/evt_sequencer.sv
module evt_sequencer
  import evt_seq_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int TS_W     = 16,
  parameter int BUCKET_W = 10,
  localparam int ADDR_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [7:0]          cfgCode,
  input  logic [TS_W-1:0]     cfgStamp,
  input  logic                cfgValid,
  input  logic [BUCKET_W-1:0] bucketNum,
  input  logic                syncPulse,
  output logic [7:0]          evtCode,
  output logic                busy
);

  seqStrobes_t strb;
  logic        atLast;

  evt_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .syncPulse(syncPulse),
    .atLast(atLast), .strb(strb), .busy(busy)
  );

  evt_seq_dpath #(.ENTRIES(ENTRIES), .TS_W(TS_W), .BUCKET_W(BUCKET_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgCode(cfgCode),
    .cfgStamp(cfgStamp), .cfgValid(cfgValid), .bucketNum(bucketNum),
    .atLast(atLast), .evtCode(evtCode)
  );

endmodule

// File: tb/test_evt_sequencer.sv
module test_evt_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [7:0]  cfgCode = '0;
  logic [15:0] cfgStamp = '0;
  logic        cfgValid = 1'b0;
  logic [9:0]  bucketNum = '0;
  logic        syncPulse = 1'b0;
  logic [7:0]  evtCode;
  logic        busy;

  int total = 0;
  int bad = 0;
  int evN;
  int evRel[64];
  int evCd[64];
  int endRel;
  bit busyAtStart;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  evt_sequencer i_evt_sequencer (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgCode(cfgCode), .cfgStamp(cfgStamp), .cfgValid(cfgValid),
    .bucketNum(bucketNum), .syncPulse(syncPulse),
    .evtCode(evtCode), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeEntry(input int addr, input int code, input int stamp, input bit valid);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'(addr); cfgCode = 8'(code);
    cfgStamp = 16'(stamp); cfgValid = valid;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearTable();
    for (int i = 0; i < 16; i++) writeEntry(i, 0, 0, 1'b0);
  endtask

  // Start a run; optionally disturb it at cycle pokeRel
  task automatic runSeq(input int bkt, input int pokeRel, input bit pokeSync,
                        input int pokeBkt, input bit pokeWr);
    int rel;
    evN = 0;
    @(negedge clk);
    bucketNum = 10'(bkt); syncPulse = 1'b1;
    @(negedge clk);
    syncPulse = 1'b0;
    rel = 0;
    busyAtStart = busy;
    chk(evtCode == 8'h00, "R4", "code at start", evtCode, 0);
    while (busy && rel < 2000) begin
      @(negedge clk);
      rel++;
      syncPulse = 1'b0; cfgWrEn = 1'b0;
      if (evtCode != 8'h00 && evN < 64) begin
        evRel[evN] = rel; evCd[evN] = evtCode; evN++;
      end
      if (rel == pokeRel) begin
        syncPulse = pokeSync;
        bucketNum = 10'(pokeBkt);
        if (pokeWr) begin
          cfgWrEn = 1'b1; cfgAddr = 4'd0; cfgCode = 8'h04;
          cfgStamp = 16'd1; cfgValid = 1'b1;
        end
      end
    end
    syncPulse = 1'b0; cfgWrEn = 1'b0;
    endRel = rel;
  endtask

  task automatic expectEv(input int rel, input int code, input string req);
    int got = 0;
    for (int i = 0; i < evN; i++) if (evRel[i] == rel) got = evCd[i];
    chk(got == code, req, $sformatf("code at cycle %0d", rel), got, code);
  endtask

  task automatic expectRun(input int nEv, input int endAt, input string req);
    chk(busyAtStart == 1'b1, "R3", "busy after start", busyAtStart, 1);
    chk(evN == nEv, req, "event count", evN, nEv);
    chk(endRel == endAt, req, "end cycle", endRel, endAt);
  endtask

  task automatic loadBasic();
    clearTable();
    writeEntry(0, 8'h01, 3, 1'b1);
    writeEntry(1, 8'h02, 5, 1'b1);
    writeEntry(2, 8'h06, 9, 1'b1);
  endtask

  task automatic testReset();
    chk(evtCode == 8'h00, "R1", "reset code", evtCode, 0);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
  endtask

  task automatic testBasic();  // R2 R3 R4 R8, bucket 3 gives no shift (R5)
    loadBasic();
    runSeq(3, -1, 0, 3, 0);
    expectEv(4, 8'h01, "R3");
    expectEv(6, 8'h02, "R2");
    expectEv(10, 8'h06, "R5");
    expectRun(3, 10, "R8");
    repeat (3) @(negedge clk);
    chk(evtCode == 8'h00 && busy == 1'b0, "R4", "idle after run", evtCode, 0);
  endtask

  task automatic testShift();  // bucket 13 -> 3 ticks
    loadBasic();
    runSeq(13, -1, 0, 13, 0);
    expectEv(4, 8'h01, "R6");
    expectEv(9, 8'h02, "R5");
    expectEv(13, 8'h06, "R5");
    expectRun(3, 13, "R8");
  endtask

  task automatic testReorder();  // shifted gun overtakes unshifted diagnostic
    clearTable();
    writeEntry(0, 8'h05, 2, 1'b1);
    writeEntry(1, 8'h06, 8, 1'b1);
    writeEntry(2, 8'h01, 10, 1'b1);
    runSeq(12, -1, 0, 12, 0);
    expectEv(3, 8'h05, "R6");
    expectEv(11, 8'h01, "R6");
    expectEv(12, 8'h06, "R8");
    expectRun(3, 12, "R8");
  endtask

  task automatic testInvalid();
    clearTable();
    writeEntry(0, 8'h01, 3, 1'b1);
    writeEntry(1, 8'h07, 20, 1'b0);
    writeEntry(2, 8'h02, 5, 1'b1);
    runSeq(0, -1, 0, 0, 0);
    expectEv(4, 8'h01, "R8");
    expectEv(6, 8'h02, "R8");
    expectRun(2, 6, "R8");
  endtask

  task automatic testCollision();  // both land on time 6 with bucket 8
    clearTable();
    writeEntry(1, 8'h08, 4, 1'b1);
    writeEntry(3, 8'h03, 4, 1'b1);
    runSeq(8, -1, 0, 8, 0);
    expectEv(7, 8'h08, "R11");
    expectRun(1, 7, "R11");
  endtask

  task automatic testBucketHold();
    loadBasic();
    runSeq(0, 2, 0, 40, 0);
    expectEv(6, 8'h02, "R7");
    expectEv(10, 8'h06, "R7");
    expectRun(3, 10, "R7");
  endtask

  task automatic testRestart();
    loadBasic();
    runSeq(0, 3, 1, 0, 0);
    expectEv(4, 8'h01, "R9");
    expectEv(10, 8'h06, "R9");
    expectRun(3, 10, "R9");
  endtask

  task automatic testLockedWrite();
    loadBasic();
    runSeq(0, 2, 0, 0, 1);
    runSeq(0, -1, 0, 0, 0);
    expectEv(4, 8'h01, "R10");
    expectEv(2, 8'h00, "R10");
    expectRun(3, 10, "R10");
  endtask

  task automatic testEmpty();
    clearTable();
    runSeq(0, -1, 0, 0, 0);
    expectRun(0, 1, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testShift();
    testReorder();
    testInvalid();
    testCollision();
    testBucketHold();
    testRestart();
    testLockedWrite();
    testEmpty();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule